// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the capture side of a serial audio input port. It never drives the bit clock or the frame clock. It receives both clocks from outside, together with four serial data lines. Both clocks and the data pass through two-stage synchronizers into the system clock domain. Every rising bit-clock edge seen there samples the data lines.

A three-bit format code selects one of five framing styles:

| Code | Format |
|------|--------|
| 0 | I2S (also used for codes 5 to 7) |
| 1 | left-justified |
| 2 | right-justified |
| 3 | 8-slot TDM with a clock-type frame signal |
| 4 | 8-slot TDM with a one-bit pulse frame signal |

A separate two-bit code picks the right-justify offset.

Each finished word is presented as a 24-bit left-aligned value with a 3-bit channel code and a one-cycle valid strobe. In the two-channel formats, a finished half-frame yields one word per data line. These words come out on consecutive system cycles. In TDM, only line 0 is used and one word is produced per slot.

The system clock must run at least eight times faster than the bit clock.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset `out_vld`, `out_word` and `out_ch` are 0. No word is emitted until the first frame start of the selected format has been seen. The word in progress at that frame start is discarded.
- R2: With `cfg_fmt` = 0 (also 5 to 7), the frame clock level selects the half: low means left (side 0) and high means right (side 1). A frame starts when the frame clock falls. The MSB of each half is the bit sampled one bit clock after the frame-clock transition.
- R3: With `cfg_fmt` = 1, a high frame clock marks the left half (side 0). The frame starts on its rising edge. The bit sampled at the first rising bit-clock edge after the transition is the MSB.
- R4: With `cfg_fmt` = 2, halves and frame start are as in R3. The first D bits of each half are skipped, and the word is taken from the bits that follow. D is 8, 12 or 16 for `cfg_rj` = 0, 1 or 2 (3 also gives 16). `cfg_rj` has no effect in the other formats.
- R5: With `cfg_fmt` = 3, a frame starts on a falling frame-clock edge. The MSB of slot 0 is the bit one bit clock later. Slots are 32 bits long and numbered 0 to 7. Slot 7 is emitted at the next frame start.
- R6: With `cfg_fmt` = 4, a frame starts on the rising edge of a one-bit-wide frame pulse. Slot timing otherwise follows R5.
- R7: For a word longer than 24 bits, the first 24 bits are kept and the rest are dropped.
- R8: For a word shorter than 24 bits, the received bits fill `out_word` from bit 23 downward. The lower bits are 0.
- R9: In the two-channel formats, each finished half yields four words on consecutive cycles, for lines 0, 1, 2 and 3 in that order. Each word's `out_ch` is 2*line + side.
- R10: In TDM formats, lines 1 to 3 have no effect. Each slot yields a single word with `out_ch` equal to the slot number.
- R11: Data is sampled on the rising bit-clock edge. A word is emitted only in response to bit-clock activity: `out_vld` stays low once the bit clock has been still for more than 12 system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 3 | Format code (see R2 to R6) |
| cfg_rj | input | 2 | Right-justify offset select |
| sck_in | input | 1 | External bit clock |
| ws_in | input | 1 | External frame clock or frame pulse |
| sd_in | input | 4 | Serial data lines 0 to 3 |
| out_word | output | 24 | Received sample, left-aligned |
| out_ch | output | 3 | Channel code of the sample |
| out_vld | output | 1 | One-cycle strobe per sample |

## Verification
The effects of a wrong internal state appear at the ports, and always within one word time:

- **Bit counter off by one:** at the next burst, every word appears shifted by a bit, or the padding bits come out non-zero.
- **Side or slot latched wrongly:** the channel codes swap between the left and right words, or shift across the TDM slots.
- **Arming fault:** a phantom word appears before the first real frame, which changes the word count.
- **Drain fault:** the line order in a burst breaks, or words are lost, which is visible in `out_ch` stepping.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int WORD_W    = 24,
  parameter int NLINE     = 4,
  parameter int LINE_W    = 2,
  parameter int CH_W      = 3,
  parameter int TDM_SLOTS = 8,
  parameter int SLOT_BITS = 32,
  parameter int CNT_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_fmt,
  input  logic [1:0]        cfg_rj,
  input  logic              sck_in,
  input  logic              ws_in,
  input  logic [NLINE-1:0]  sd_in,
  output logic [WORD_W-1:0] out_word,
  output logic [CH_W-1:0]   out_ch,
  output logic              out_vld
);
  localparam logic [CNT_W-1:0]  CNT_TOP   = '1;
  localparam logic [CNT_W-1:0]  SLOT_LEN  = CNT_W'(SLOT_BITS);
  localparam logic [CNT_W-1:0]  WLEN      = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0]  ONE_C     = CNT_W'(1);
  localparam logic [CH_W-1:0]   LAST_SLOT = CH_W'(TDM_SLOTS - 1);
  localparam logic [CH_W-1:0]   ONE_ID    = CH_W'(1);
  localparam logic [LINE_W:0]   LEFT_ALL  = (LINE_W+1)'(NLINE);
  localparam logic [LINE_W:0]   LEFT_ONE  = (LINE_W+1)'(1);
  localparam logic [LINE_W-1:0] ONE_L     = LINE_W'(1);
  localparam logic [WORD_W-1:0] TOP_BIT   = {1'b1, {(WORD_W-1){1'b0}}};

  logic [1:0]        sck_sy, ws_sy;
  logic [NLINE-1:0]  sd_s1, sd_s2;
  logic              sck_d, ws_p1, ws_p2, armed, hold_tdm;
  logic [CNT_W-1:0]  cnt;
  logic [CH_W-1:0]   cur_id, hold_id;
  logic [WORD_W-1:0] acc     [NLINE];
  logic [WORD_W-1:0] acc_nxt [NLINE];
  logic [WORD_W-1:0] hold    [NLINE];
  logic [LINE_W:0]   left;
  logic [LINE_W-1:0] didx;

  wire rise   = sck_sy[1] & ~sck_d;
  wire ws_now = ws_sy[1];
  wire is_lj  = (cfg_fmt == 3'd1);
  wire is_rj  = (cfg_fmt == 3'd2);
  wire is_tc  = (cfg_fmt == 3'd3);
  wire is_tp  = (cfg_fmt == 3'd4);
  wire is_tdm = is_tc | is_tp;
  wire is_i2s = ~(is_lj | is_rj | is_tdm);

  wire late_fall = ~ws_p1 & ws_p2;
  wire late_rise = ws_p1 & ~ws_p2;
  wire fstart    = is_tp ? late_rise :
                   (is_tc | is_i2s) ? late_fall : (ws_now & ~ws_p1);
  wire half_edge = is_i2s ? (ws_p1 ^ ws_p2) : (ws_now ^ ws_p1);
  wire slot_end  = (cnt == SLOT_LEN) && (cur_id != LAST_SLOT);
  wire wb        = is_tdm ? (fstart | slot_end) : half_edge;
  wire emit      = rise & wb & armed;

  wire [CNT_W-1:0] skip = !is_rj ? '0 :
                          (cfg_rj == 2'd0) ? CNT_W'(8) :
                          (cfg_rj == 2'd1) ? CNT_W'(12) : CNT_W'(16);
  wire [CNT_W-1:0] pos  = wb ? '0 : cnt;
  wire [CNT_W-1:0] off  = pos - skip;
  wire             take = (pos >= skip) && (off < WLEN);
  wire [WORD_W-1:0] mask = take ? (TOP_BIT >> off) : '0;
  wire [CH_W-1:0] nxt_id = is_tdm ? (fstart ? '0 : cur_id + ONE_ID)
                                  : CH_W'(is_i2s ? ws_p1 : ~ws_now);

  always_comb begin
    for (int i = 0; i < NLINE; i++)
      acc_nxt[i] = (wb ? '0 : acc[i]) | (sd_s2[i] ? mask : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      ws_sy  <= '0;
      sd_s1  <= '0;
      sd_s2  <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[0], sck_in};
      ws_sy  <= {ws_sy[0], ws_in};
      sd_s1  <= sd_in;
      sd_s2  <= sd_s1;
      sck_d  <= sck_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_p1  <= 1'b0;
      ws_p2  <= 1'b0;
      cnt    <= '0;
      cur_id <= '0;
      armed  <= 1'b0;
      acc    <= '{default: '0};
    end else if (rise) begin
      ws_p1 <= ws_now;
      ws_p2 <= ws_p1;
      cnt   <= (pos == CNT_TOP) ? pos : pos + ONE_C;
      acc   <= acc_nxt;
      if (wb)     cur_id <= nxt_id;
      if (fstart) armed  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '{default: '0};
      hold_id  <= '0;
      hold_tdm <= 1'b0;
      left     <= '0;
      didx     <= '0;
      out_word <= '0;
      out_ch   <= '0;
      out_vld  <= 1'b0;
    end else begin
      out_vld <= (left != '0);
      if (left != '0) begin
        out_word <= hold[didx];
        out_ch   <= hold_tdm ? hold_id : CH_W'({didx, hold_id[0]});
        didx     <= didx + ONE_L;
        left     <= left - LEFT_ONE;
      end
      if (emit) begin
        hold     <= acc;
        hold_id  <= cur_id;
        hold_tdm <= is_tdm;
        left     <= is_tdm ? LEFT_ONE : LEFT_ALL;
        didx     <= '0;
      end
    end
  end
endmodule

module serial_audio_rx_chk #(
  parameter int NLINE = 4,
  parameter int CH_W  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sck_in,
  input logic [2:0]      cfg_fmt,
  input logic            out_vld,
  input logic [CH_W-1:0] out_ch
);
  logic       sck_q;
  logic [7:0] quiet;
  logic [7:0] run;
  wire        tdm_mode = (cfg_fmt == 3'd3) || (cfg_fmt == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      quiet <= '0;
      run   <= '0;
    end else begin
      sck_q <= sck_in;
      if (sck_in != sck_q) quiet <= '0;
      else if (quiet != 8'hFF) quiet <= quiet + 8'd1;
      run <= out_vld ? run + 8'd1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R1: assert (!out_vld);
  end

  assert_burst_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (run < 8'(NLINE)));

  assert_ch_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(out_vld)) |-> (out_ch == $past(out_ch) + CH_W'(2)));

  assert_first_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !$past(out_vld) && !tdm_mode) |-> (out_ch[CH_W-1:1] == '0));

  assert_tdm_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && tdm_mode && $past(tdm_mode)) |=> !out_vld);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet > 8'd12) |-> !out_vld);
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.NLINE(NLINE), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .cfg_fmt(cfg_fmt),
  .out_vld(out_vld), .out_ch(out_ch)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BCK   = 4;
  localparam int MAXW       = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_fmt = 3'd0;
  logic [1:0]  cfg_rj = 2'd0;
  logic        sck = 1'b0;
  logic        ws = 1'b0;
  logic [3:0]  sd = 4'd0;
  logic [23:0] out_word;
  logic [2:0]  out_ch;
  logic        out_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_rj(cfg_rj),
    .sck_in(sck), .ws_in(ws), .sd_in(sd),
    .out_word(out_word), .out_ch(out_ch), .out_vld(out_vld)
  );

  int n_chk = 0, n_bad = 0;
  logic [23:0] exp_w [MAXW];
  logic [2:0]  exp_c [MAXW];
  logic [23:0] got_w [MAXW];
  logic [2:0]  got_c [MAXW];
  int n_exp = 0, n_got = 0;

  always @(negedge clk) begin
    if (out_vld && n_got < MAXW) begin
      got_w[n_got] = out_word;
      got_c[n_got] = out_ch;
      n_got = n_got + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  function automatic logic [31:0] pat(input int s, input int n);
    return (32'h9E3779B9 * 32'(n + 1)) ^ (32'h01234567 + 32'(s * 977));
  endfunction

  function automatic logic [23:0] expect_word(input logic [31:0] v, input int w);
    logic [31:0] m;
    m = (w >= 32) ? v : (v & ((32'd1 << w) - 32'd1));
    if (w >= 24) return 24'(m >> (w - 24));
    return 24'(m << (24 - w));
  endfunction

  task automatic send_bit(input logic w, input logic [3:0] d);
    sck = 1'b0; ws = w; sd = d;
    repeat (HALF_BCK) @(negedge clk);
    sck = 1'b1;
    repeat (HALF_BCK) @(negedge clk);
  endtask

  task automatic start(input logic [2:0] fmt, input logic [1:0] rj, input logic idle_ws);
    @(negedge clk);
    rst_n = 1'b0; cfg_fmt = fmt; cfg_rj = rj; sck = 1'b0; ws = idle_ws; sd = 4'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    n_got = 0; n_exp = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input string req);
    repeat (40) @(negedge clk);
    chk(n_got == n_exp, {req, " word count"}, n_got, n_exp);
    for (int i = 0; i < n_exp; i++)
      chk(got_w[i] == exp_w[i] && got_c[i] == exp_c[i], req,
          {5'd0, got_c[i], got_w[i]}, {5'd0, exp_c[i], exp_w[i]});
  endtask

  // two-channel formats: fmt 0 I2S, 1 left-justified, 2 right-justified
  task automatic run2(input logic [2:0] fmt, input logic [1:0] rj, input int hb,
                      input int w, input int nf, input int seed, input string req);
    int o;
    logic lft;
    logic [31:0] v [4];
    logic [3:0] d;
    o   = (fmt == 3'd0) ? 1 : (fmt == 3'd1) ? 0 : (rj == 2'd0) ? 8 : (rj == 2'd1) ? 12 : 16;
    lft = (fmt == 3'd0) ? 1'b0 : 1'b1;
    start(fmt, rj, ~lft);
    for (int p = 0; p < 3; p++) send_bit(~lft, 4'd0);
    for (int h = 0; h < 2*(nf+1); h++) begin
      for (int l = 0; l < 4; l++) v[l] = pat(seed, h*4 + l);
      for (int j = 0; j < hb; j++) begin
        for (int l = 0; l < 4; l++)
          d[l] = (j - o >= 0 && j - o < w) ? v[l][w-1-(j-o)] : 1'b0;
        send_bit((h % 2) ? ~lft : lft, d);
      end
      if (h < 2*(nf+1) - 1)
        for (int l = 0; l < 4; l++) begin
          exp_w[n_exp] = expect_word(v[l], w);
          exp_c[n_exp] = 3'(l*2 + (h % 2));
          n_exp++;
        end
    end
    compare(req);
  endtask

  // TDM formats: fmt 3 clock-type frame, fmt 4 pulse frame; 8 slots of 32 bits
  task automatic runt(input logic [2:0] fmt, input int w, input int nf,
                      input int seed, input string req);
    logic [31:0] v;
    logic [3:0] d;
    logic wv;
    int p;
    start(fmt, 2'd0, (fmt == 3'd3));
    for (int q = 0; q < 3; q++) send_bit(fmt == 3'd3, 4'd0);
    for (int f = 0; f < nf + 1; f++) begin
      for (int s = 0; s < 8; s++)
        if (f < nf || s < 7) begin
          exp_w[n_exp] = expect_word(pat(seed, f*8 + s), w);
          exp_c[n_exp] = 3'(s);
          n_exp++;
        end
      for (int j = 0; j < 256; j++) begin
        p  = j - 1;
        wv = (fmt == 3'd3) ? (j >= 128) : (j == 0);
        d[3:1] = 3'(j*5 + f + 1);
        if (p >= 0 && (p % 32) < w) begin
          v = pat(seed, f*8 + p/32);
          d[0] = v[w-1-(p%32)];
        end else d[0] = 1'b0;
        send_bit(wv, d);
      end
    end
    compare(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R1 reset valid", out_vld, 0);
    chk(out_word == 24'd0, "R1 reset word", out_word, 0);
    chk(out_ch == 3'd0, "R1 reset channel", out_ch, 0);
    run2(3'd0, 2'd0, 32, 24, 3, 1, "R2 R9 R11 R1 i2s w24");
    run2(3'd0, 2'd3, 32, 16, 3, 2, "R2 R8 R4 i2s w16");
    run2(3'd0, 2'd0, 32, 31, 2, 3, "R2 R7 i2s w31");
    run2(3'd1, 2'd0, 32, 32, 2, 4, "R3 R7 lj w32");
    run2(3'd1, 2'd2, 24, 20, 3, 5, "R3 R8 lj w20");
    run2(3'd2, 2'd0, 32, 24, 2, 6, "R4 rj delay8");
    run2(3'd2, 2'd1, 32, 20, 2, 7, "R4 R8 rj delay12");
    run2(3'd2, 2'd2, 32, 16, 2, 8, "R4 rj delay16");
    runt(3'd3, 24, 2, 9, "R5 R10 tdm clock w24");
    runt(3'd3, 32, 1, 10, "R5 R7 tdm clock w32");
    runt(3'd4, 16, 2, 11, "R6 R8 R10 tdm pulse w16");
    runt(3'd4, 24, 1, 12, "R6 tdm pulse w24");
    summary();
    $finish;
  end
endmodule